// File: doc/BRIEF.md
# Edge-Kicked Watchdog Fault Monitor

This block is a synchronous watchdog timer. Software or a companion device keeps it satisfied by making the kick input change level. Either a rising or a falling transition counts as a kick, and each kick restarts the timeout window. If a whole window passes with no transition, the active-low fault output drops. It stays low until the next kick arrives or until the watchdog is disabled. A kick input held permanently high or permanently low is treated as a dead source and leads to a fault.

Three qualifier inputs switch the watchdog off. These are a supply-good flag that has gone low, a flag saying the kick line is floating, and an active system reset. While any of them is active, the counter is held at zero and the fault output is forced high. When the last of them is released, timing starts again from zero. The kick input is asynchronous. It passes through a two-stage synchronizer before edge detection. The window length is a parameter given in clock cycles. The default equals a 1.6 s window at 250 MHz.

Top module: `wdog_fault_monitor`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `fault_n_o` is high and no fault can appear until a full window has elapsed.
- R2: A rising or falling transition on `kick_i` is seen by the timer on the third rising clock edge after the transition (two synchronizer stages plus the edge register). That edge clears the count and drives `fault_n_o` high.
- R3: When the watchdog is enabled and the count starts from zero, `fault_n_o` goes low on exactly the `TIMEOUT_CYC`-th rising edge that carries no kick. It is still high after `TIMEOUT_CYC`-1 such edges.
- R4: A `kick_i` held constantly low and a `kick_i` held constantly high both produce a fault after `TIMEOUT_CYC` cycles.
- R5: Once low, `fault_n_o` stays low until a kick reaches the timer, and then it returns high (third edge after the transition).
- R6: `supply_ok_i` low forces `fault_n_o` high from the next rising edge and holds the count at zero for as long as it stays low.
- R7: `kick_float_i` high forces `fault_n_o` high from the next rising edge and holds the count at zero.
- R8: `sys_rst_i` high clears the count and returns `fault_n_o` high from the next rising edge.
- R9: After every disable condition has been removed, timing restarts from zero with no kick needed. The fault appears exactly `TIMEOUT_CYC` edges later if no kick arrives.
- R10: Transitions on `kick_i` while the watchdog is disabled have no effect. They neither hold off nor advance the fault after re-enable, provided the last of them comes at least three cycles before the release.
- R11: Kicks spaced exactly `TIMEOUT_CYC` cycles apart keep `fault_n_o` high indefinitely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| kick_i | input | 1 | Asynchronous kick line; any transition is a kick |
| supply_ok_i | input | 1 | High when supply is above threshold; low disables |
| kick_float_i | input | 1 | High when the kick line is detected as open; disables |
| sys_rst_i | input | 1 | High while system reset is asserted; disables and clears |
| fault_n_o | output | 1 | Registered active-low watchdog fault |

## Verification
The hardest case to reach from the ports is the exact boundary of the window. One test spaces kicks exactly `TIMEOUT_CYC` cycles apart, where the count reaches its terminal value on the same edge the kick arrives. A second test releases a disable with kick activity that has only just drained out of the synchronizer. The bench sets up both conditions by driving kick transitions on the falling edge at known distances. It counts the three-register latency into every expectation. In the disable tests it ends kick toggling more than three cycles before release, then measures the fault edge to the exact cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Counter width for a window of n cycles (terminal value n-1).
  function automatic int cnt_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/wdog_kick_sync.sv
module wdog_kick_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic kick_i,
  output logic kick_edge_o
);
  // pipe[0..SYNC_STAGES-1] synchronize, pipe[SYNC_STAGES] holds previous level
  logic [SYNC_STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '0;
    end else begin
      pipe[0] <= kick_i;
      for (int i = 1; i <= SYNC_STAGES; i++) begin
        pipe[i] <= pipe[i-1];
      end
    end
  end

  assign kick_edge_o = pipe[SYNC_STAGES] ^ pipe[SYNC_STAGES-1];
endmodule

// File: rtl/wdog_window_timer.sv
module wdog_window_timer #(
  parameter int TIMEOUT_CYC = 20,
  parameter int CNT_W       = wdog_pkg::cnt_width(TIMEOUT_CYC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold_clr,
  input  logic             kick_edge,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] TERM = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || hold_clr || kick_edge) begin
      cnt_q <= '0;
    end else if (cnt_q != TERM) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o    = cnt_q;
  assign expire_o = (cnt_q == TERM) && !kick_edge && !hold_clr;

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= TERM);
endmodule

// File: rtl/wdog_fault_reg.sv
module wdog_fault_reg (
  input  logic clk,
  input  logic rst,
  input  logic hold_clr,
  input  logic kick_edge,
  input  logic expire,
  output logic fault_n_o
);
  logic fault_n_q;

  always_ff @(posedge clk) begin
    if (rst || hold_clr || kick_edge) begin
      fault_n_q <= 1'b1;
    end else if (expire) begin
      fault_n_q <= 1'b0;
    end
  end

  assign fault_n_o = fault_n_q;
endmodule

// File: rtl/wdog_fault_monitor.sv
module wdog_fault_monitor #(
  parameter int TIMEOUT_CYC = 400_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic kick_i,
  input  logic supply_ok_i,
  input  logic kick_float_i,
  input  logic sys_rst_i,
  output logic fault_n_o
);
  localparam int CNT_W = wdog_pkg::cnt_width(TIMEOUT_CYC);
  localparam logic [CNT_W-1:0] TERM = CNT_W'(TIMEOUT_CYC - 1);

  logic             kick_edge;
  logic             hold_clr;
  logic             expire;
  logic [CNT_W-1:0] cnt;

  assign hold_clr = !supply_ok_i || kick_float_i || sys_rst_i;

  wdog_kick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .rst         (rst),
    .kick_i      (kick_i),
    .kick_edge_o (kick_edge)
  );

  wdog_window_timer #(.TIMEOUT_CYC(TIMEOUT_CYC), .CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .hold_clr  (hold_clr),
    .kick_edge (kick_edge),
    .cnt_o     (cnt),
    .expire_o  (expire)
  );

  wdog_fault_reg u_fault (
    .clk       (clk),
    .rst       (rst),
    .hold_clr  (hold_clr),
    .kick_edge (kick_edge),
    .expire    (expire),
    .fault_n_o (fault_n_o)
  );

  // R6 R7 R8
  disable_forces_high_chk: assert property (@(posedge clk) disable iff (rst)
    (!supply_ok_i || kick_float_i || sys_rst_i) |=> (fault_n_o && cnt == '0));

  // R3
  fault_only_at_term_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(fault_n_o) |-> ($past(cnt) == TERM));

  // R2
  kick_restarts_chk: assert property (@(posedge clk) disable iff (rst)
    (kick_edge && supply_ok_i && !kick_float_i && !sys_rst_i)
      |=> (fault_n_o && cnt == '0));

  // R5
  fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!fault_n_o && !kick_edge && supply_ok_i && !kick_float_i && !sys_rst_i)
      |=> !fault_n_o);
endmodule

// File: tb/wdog_fault_monitor_tb.sv
module wdog_fault_monitor_tb;
  localparam int T = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic kick_i = 1'b0;
  logic supply_ok_i = 1'b1;
  logic kick_float_i = 1'b0;
  logic sys_rst_i = 1'b0;
  logic fault_n_o;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  wdog_fault_monitor #(.TIMEOUT_CYC(T)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .kick_i       (kick_i),
    .supply_ok_i  (supply_ok_i),
    .kick_float_i (kick_float_i),
    .sys_rst_i    (sys_rst_i),
    .fault_n_o    (fault_n_o)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: fault_n_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Count starts at zero at this negedge with no kick in flight.
  task automatic expect_timeout(input string req);
    step(T - 1);
    check(req, fault_n_o, 1'b1);
    step(1);
    check(req, fault_n_o, 1'b0);
  endtask

  task automatic t_reset();
    step(3);
    check("R1", fault_n_o, 1'b1);
    rst = 1'b0;
    check("R1", fault_n_o, 1'b1);
    // kick held low: R3 and R4 (constant low)
    expect_timeout("R3/R4 low");
  endtask

  task automatic t_recover();
    kick_i = 1'b1;
    step(2);
    check("R5 still low", fault_n_o, 1'b0);
    step(1);
    check("R2/R5 kick clears", fault_n_o, 1'b1);
    // kick now held high: R4 (constant high)
    expect_timeout("R4 high");
  endtask

  task automatic t_periodic();
    logic ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      kick_i = ~kick_i;
      for (int j = 1; j <= T; j++) begin
        step(1);
        if ((i > 0 || j >= 3) && fault_n_o !== 1'b1) ok = 1'b0;
      end
    end
    check("R11 periodic kicks", ok, 1'b1);
    step(T + 2);
    check("R3 after kicks stop", fault_n_o, 1'b0);
  endtask

  task automatic t_disable(input int which, input string req);
    logic ok = 1'b1;
    check({req, " precondition"}, fault_n_o, 1'b0);
    case (which)
      0: supply_ok_i = 1'b0;
      1: kick_float_i = 1'b1;
      default: sys_rst_i = 1'b1;
    endcase
    step(1);
    check(req, fault_n_o, 1'b1);
    for (int k = 0; k < 3 * T; k++) begin
      if (k % 5 == 0 && k < 3 * T - 6) kick_i = ~kick_i;
      step(1);
      if (fault_n_o !== 1'b1) ok = 1'b0;
    end
    check({req, " held"}, ok, 1'b1);
    supply_ok_i = 1'b1;
    kick_float_i = 1'b0;
    sys_rst_i = 1'b0;
    expect_timeout("R9/R10 restart");
  endtask

  initial begin
    t_reset();
    t_recover();
    t_periodic();
    t_disable(0, "R6 supply low");
    t_disable(1, "R7 float");
    t_disable(2, "R8 sys reset");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule